// File: doc/BRIEF.md
# Off-State Load Diagnostic Sequencer

This controller runs a passive load check on the two outputs of an H-bridge driver while the power stage stays off. A start pulse captures the requested load topology (full bridge, low-side loads or high-side loads), the settle time and a latched over-current flag from earlier active operation. The controller then walks the driver's control lines (wake, drive-off, IN1, IN2 and a two-bit pull/reference select code) through a fixed list of setup steps. For each step it waits out a settle interval and takes one sample of the synchronized comparator input.

When the last step is done, the recorded comparator pattern is decoded into a three-bit fault code for each output. The codes stay on the result ports until the next accepted start. The pull resistors, the comparator and the reference levels sit in the analog driver. This block does only the digital stepping and the classification.

Top module: `offdiag_seq`

## Requirements
- R1: After reset and whenever not busy, the control outputs take their idle values: wake=0, drive_off=1, in1=0, in2=0, pull_sel=00. In addition busy=0, done=0, and both result codes are 000.
- R2: In every cycle in which a diagnostic step is applied, wake=1 and drive_off=1.
- R3: For load_sel 00 (full bridge) or 11 (treated as full bridge), exactly three steps are applied, in this order as {in1,in2,pull_sel}: {1,0,00}, {0,1,00}, {1,1,00}.
- R4: Full-bridge decode of the samples (step1,step2,step3). The codes are 000 normal, 001 open, 010 short to ground, 011 short to supply, and both outputs receive the same code. The mapping is: (0,1,1) gives 000; (1,0,1) gives 001; (0,0,0) gives 010; (1,1,1) gives 011.
- R5: For load_sel 01 (low-side) or 10 (high-side), exactly four steps are applied, in this order: {1,0,01}, {1,0,11}, {0,1,01}, {0,1,11}. The first two test OUT1 and the last two test OUT2. Code 01 selects pull-up with the high reference, and 11 selects pull-down with the low reference.
- R6: Low-side decode per output, as (pull-up sample, pull-down sample): (0,0) gives 000, (1,0) gives 001, (1,1) gives 011.
- R7: High-side decode per output, as (pull-up sample, pull-down sample): (1,1) gives 000, (1,0) gives 001, (0,0) gives 010.
- R8: Any sample pattern not listed in R4, R6 or R7 yields 111 (indeterminate) for the affected output (for the full bridge, both outputs).
- R9: If ocp_flag was 1 at the accepted start and both outputs decode as 000, both results become 100 (terminal short). Fault codes are otherwise unaffected by ocp_flag.
- R10: The settle value is captured at start, and values below 2 are raised to 2. Each step lasts settle+1 cycles. The comparator passes through a two-flop synchronizer and is sampled in the last cycle of the step. busy stays high for steps*(settle+1)+1 cycles.
- R11: busy rises in the cycle after an accepted start. A start pulse while busy is ignored, and so are changes to load_sel, settle or ocp_flag after the start.
- R12: At an accepted start both results clear to 000. At the end of the run, done pulses for exactly one cycle as busy falls, together with the new results. The results then hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, honoured only when idle |
| load_sel_i | input | 2 | Load topology: 00 full, 01 low-side, 10 high-side, 11 full |
| settle_i | input | SETTLE_W | Settle cycles per step (minimum 2 applied) |
| ocp_flag_i | input | 1 | Latched over-current flag from active operation |
| cmp_i | input | 1 | Asynchronous comparator output from the driver |
| wake_o | output | 1 | Driver wake line |
| drive_off_o | output | 1 | Driver output-disable line |
| in1_o | output | 1 | Driver IN1 |
| in2_o | output | 1 | Driver IN2 |
| pull_sel_o | output | 2 | Pull and reference select code |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| res_out1_o | output | 3 | Fault code for OUT1 |
| res_out2_o | output | 3 | Fault code for OUT2 |

## Verification
Several properties are checked in every cycle. The FETs-off condition and the idle line values are checked, as is the settle counter's floor and its step-by-step countdown. The synchronizer's one-stage lag, the freeze of the captured configuration during a run, the single-cycle done pulse and the stability of held results are also checked each cycle. The step order and the fault classification can only be shown by the bench's scenarios. A load model in the bench answers each applied setup with the comparator level of a chosen fault. The bench sweeps every fault combination of each topology with and without the over-current flag, and also covers a start issued mid-run.

// File: rtl/offdiag_pkg.sv
// Shared types and constants for the off-state diagnostic sequencer.
package offdiag_pkg;
    localparam int MAX_STEPS = 4;
    localparam int IDX_W     = $clog2(MAX_STEPS);

    localparam logic [1:0] LOAD_FULL = 2'b00;
    localparam logic [1:0] LOAD_LOW  = 2'b01;
    localparam logic [1:0] LOAD_HIGH = 2'b10;
    localparam logic [1:0] LOAD_ALT  = 2'b11;

    localparam logic [1:0] SEL_NONE = 2'b00;
    localparam logic [1:0] SEL_PU   = 2'b01;
    localparam logic [1:0] SEL_PD   = 2'b11;

    typedef enum logic [2:0] {
        RES_OK   = 3'b000,
        RES_OPEN = 3'b001,
        RES_GND  = 3'b010,
        RES_VM   = 3'b011,
        RES_TERM = 3'b100,
        RES_UNK  = 3'b111
    } res_e;

    typedef struct packed {
        logic       in1;
        logic       in2;
        logic [1:0] sel;
    } step_t;
endpackage

// File: rtl/offdiag_sync.sv
// Multi-flop synchronizer for the asynchronous comparator input.
// Assumes the input is a level that stays put for several cycles.
module offdiag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];

    assert_sync_lag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q[STAGES-1] == $past(chain_q[STAGES-2]) || $past(!rst_n))
        else $error("synchronizer lag broken");
endmodule

// File: rtl/offdiag_settle.sv
// Settle countdown. A load puts max(settle, MIN_SETTLE) into the counter,
// which then counts down to zero and stays there. expire_o marks the
// sampling cycle. MIN_SETTLE covers the synchronizer latency.
module offdiag_settle #(
    parameter int SETTLE_W   = 8,
    parameter int MIN_SETTLE = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [SETTLE_W-1:0] settle_i,
    output logic                expire_o
);
    localparam logic [SETTLE_W-1:0] MIN_LD = SETTLE_W'(MIN_SETTLE);

    logic [SETTLE_W-1:0] cnt_q;

    // Load with the floored settle value, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= (settle_i < MIN_LD) ? MIN_LD : settle_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = (cnt_q == '0);

    assert_settle_floor_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q >= MIN_LD)
        else $error("settle below floor");

    assert_settle_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1)
        else $error("settle countdown skipped");
endmodule

// File: rtl/offdiag_step_rom.sv
// Setup step table: maps topology and step index to control line values.
// Purely combinational. last_o flags the final step of the topology.
module offdiag_step_rom
    import offdiag_pkg::*;
(
    input  logic             full_i,
    input  logic [IDX_W-1:0] idx_i,
    output step_t            step_o,
    output logic             last_o
);
    // Select the setup for the current step.
    always_comb begin
        step_o = '{in1: 1'b0, in2: 1'b0, sel: SEL_NONE};
        if (full_i) begin
            case (idx_i)
                2'd0:    step_o = '{in1: 1'b1, in2: 1'b0, sel: SEL_NONE};
                2'd1:    step_o = '{in1: 1'b0, in2: 1'b1, sel: SEL_NONE};
                default: step_o = '{in1: 1'b1, in2: 1'b1, sel: SEL_NONE};
            endcase
            last_o = (idx_i == IDX_W'(2));
        end else begin
            // Bit 1 of the index picks the output, bit 0 picks pull-up or pull-down.
            step_o.in1 = ~idx_i[1];
            step_o.in2 =  idx_i[1];
            step_o.sel = idx_i[0] ? SEL_PD : SEL_PU;
            last_o     = (idx_i == IDX_W'(MAX_STEPS - 1));
        end
    end
endmodule

// File: rtl/offdiag_classify.sv
// Decodes the recorded comparator samples into per-output fault codes.
// Sample bit k holds step k. In the independent topologies bits 2g and
// 2g+1 are the pull-up and pull-down samples of output g.
module offdiag_classify
    import offdiag_pkg::*;
(
    input  logic                 full_i,
    input  logic                 high_i,
    input  logic                 ocp_i,
    input  logic [MAX_STEPS-1:0] pat_i,
    output logic [2:0]           res1_o,
    output logic [2:0]           res2_o
);
    localparam int NOUT = 2;

    logic [2:0] full_code;
    logic [2:0] ind_code [NOUT];
    logic [2:0] raw      [NOUT];

    // Full-bridge pattern decode over the three steps.
    always_comb begin
        case ({pat_i[0], pat_i[1], pat_i[2]})
            3'b011:  full_code = RES_OK;
            3'b101:  full_code = RES_OPEN;
            3'b000:  full_code = RES_GND;
            3'b111:  full_code = RES_VM;
            default: full_code = RES_UNK;
        endcase
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        logic pu, pd;
        assign pu = pat_i[2*g];
        assign pd = pat_i[2*g+1];

        // Per-output decode for low-side or high-side loads.
        always_comb begin
            if (high_i) begin
                case ({pu, pd})
                    2'b11:   ind_code[g] = RES_OK;
                    2'b10:   ind_code[g] = RES_OPEN;
                    2'b00:   ind_code[g] = RES_GND;
                    default: ind_code[g] = RES_UNK;
                endcase
            end else begin
                case ({pu, pd})
                    2'b00:   ind_code[g] = RES_OK;
                    2'b10:   ind_code[g] = RES_OPEN;
                    2'b11:   ind_code[g] = RES_VM;
                    default: ind_code[g] = RES_UNK;
                endcase
            end
        end

        assign raw[g] = full_i ? full_code : ind_code[g];
    end

    // An all-normal result after an over-current event points to a terminal short.
    always_comb begin
        if (ocp_i && raw[0] == RES_OK && raw[1] == RES_OK) begin
            res1_o = RES_TERM;
            res2_o = RES_TERM;
        end else begin
            res1_o = raw[0];
            res2_o = raw[1];
        end
    end
endmodule

// File: rtl/offdiag_seq.sv
// Off-state diagnostic sequencer top. Captures topology, settle time and
// the over-current flag at start, steps the driver's control lines through
// the setup table, samples the synchronized comparator once per step and
// publishes per-output fault codes. Assumes the driver holds its FETs off
// whenever drive_off is high.
module offdiag_seq
    import offdiag_pkg::*;
#(
    parameter int SETTLE_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [1:0]          load_sel_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic                ocp_flag_i,
    input  logic                cmp_i,
    output logic                wake_o,
    output logic                drive_off_o,
    output logic                in1_o,
    output logic                in2_o,
    output logic [1:0]          pull_sel_o,
    output logic                busy_o,
    output logic                done_o,
    output logic [2:0]          res_out1_o,
    output logic [2:0]          res_out2_o
);
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FINISH} state_e;

    state_e                state_q;
    logic [1:0]            mode_q;
    logic                  ocp_q;
    logic [SETTLE_W-1:0]   settle_q;
    logic [IDX_W-1:0]      idx_q;
    logic [MAX_STEPS-1:0]  pat_q;
    logic [2:0]            res1_q, res2_q;
    logic                  done_q;

    logic                  full, high, run, start_ok, last, expire, load, cmp_s;
    logic [2:0]            cls1, cls2;
    step_t                 step;

    assign full     = (mode_q == LOAD_FULL) || (mode_q == LOAD_ALT);
    assign high     = (mode_q == LOAD_HIGH);
    assign run      = (state_q == ST_RUN);
    assign start_ok = start_i && (state_q == ST_IDLE);
    assign load     = start_ok || (run && expire && !last);

    offdiag_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(cmp_i), .q_o(cmp_s)
    );

    offdiag_settle #(.SETTLE_W(SETTLE_W), .MIN_SETTLE(SYNC_STAGES)) u_settle (
        .clk(clk), .rst_n(rst_n), .load_i(load),
        .settle_i(start_ok ? settle_i : settle_q), .expire_o(expire)
    );

    offdiag_step_rom u_rom (
        .full_i(full), .idx_i(idx_q), .step_o(step), .last_o(last)
    );

    offdiag_classify u_cls (
        .full_i(full), .high_i(high), .ocp_i(ocp_q), .pat_i(pat_q),
        .res1_o(cls1), .res2_o(cls2)
    );

    // Sequencer: capture at start, sample each step, publish at finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= LOAD_FULL;
            ocp_q    <= 1'b0;
            settle_q <= '0;
            idx_q    <= '0;
            pat_q    <= '0;
            res1_q   <= RES_OK;
            res2_q   <= RES_OK;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start_i) begin
                    mode_q   <= load_sel_i;
                    ocp_q    <= ocp_flag_i;
                    settle_q <= settle_i;
                    idx_q    <= '0;
                    pat_q    <= '0;
                    res1_q   <= RES_OK;
                    res2_q   <= RES_OK;
                    state_q  <= ST_RUN;
                end
                ST_RUN: if (expire) begin
                    pat_q[idx_q] <= cmp_s;
                    if (last) state_q <= ST_FINISH;
                    else      idx_q   <= idx_q + 1'b1;
                end
                default: begin
                    res1_q  <= cls1;
                    res2_q  <= cls2;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign wake_o      = run;
    assign drive_off_o = 1'b1;
    assign in1_o       = run & step.in1;
    assign in2_o       = run & step.in2;
    assign pull_sel_o  = run ? step.sel : SEL_NONE;
    assign busy_o      = (state_q != ST_IDLE);
    assign done_o      = done_q;
    assign res_out1_o  = res1_q;
    assign res_out2_o  = res2_q;

    assert_fets_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (wake_o && drive_off_o))
        else $error("step applied with FETs enabled");

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!wake_o && drive_off_o && !in1_o && !in2_o && pull_sel_o == SEL_NONE))
        else $error("idle control lines wrong");

    assert_sel_by_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (full ? (pull_sel_o == SEL_NONE) : (pull_sel_o != SEL_NONE)))
        else $error("select code does not match topology");

    assert_config_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(mode_q) && $stable(ocp_q) && $stable(settle_q)))
        else $error("configuration changed during run");

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o)
        else $error("done longer than one cycle");

    assert_results_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(res_out1_o) && $stable(res_out2_o)))
        else $error("results changed while idle");

    assert_terminal_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_out1_o == RES_TERM) |-> (res_out2_o == RES_TERM))
        else $error("terminal short on one output only");
endmodule

// File: tb/offdiag_seq_bench.sv
module offdiag_seq_bench;
    localparam int SW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] load_sel = 2'b00;
    logic [SW-1:0] settle = '0;
    logic ocp = 1'b0;
    logic cmp;
    logic wake, doff, in1, in2, busy, done;
    logic [1:0] psel;
    logic [2:0] r1, r2;

    int checks = 0;
    int failures = 0;

    // Load model state: topology and per-output scenarios.
    logic [1:0] m_mode = 2'b00;
    int sc1 = 0, sc2 = 0;

    always #4 clk = ~clk;

    offdiag_seq #(.SETTLE_W(SW)) u_offdiag_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .load_sel_i(load_sel),
        .settle_i(settle), .ocp_flag_i(ocp), .cmp_i(cmp),
        .wake_o(wake), .drive_off_o(doff), .in1_o(in1), .in2_o(in2),
        .pull_sel_o(psel), .busy_o(busy), .done_o(done),
        .res_out1_o(r1), .res_out2_o(r2)
    );

    // Full-bridge scenario samples as {step1,step2,step3}: normal, open, gnd, vm, bad.
    function automatic logic [2:0] full_pat(int s);
        case (s)
            0: return 3'b011;
            1: return 3'b101;
            2: return 3'b000;
            3: return 3'b111;
            default: return 3'b001;
        endcase
    endfunction

    // Independent scenario samples as {pu,pd}.
    function automatic logic [1:0] ind_pat(logic hs, int s);
        if (hs) case (s) 0: return 2'b11; 1: return 2'b10; 2: return 2'b00; default: return 2'b01; endcase
        else    case (s) 0: return 2'b00; 1: return 2'b10; 2: return 2'b11; default: return 2'b01; endcase
    endfunction

    function automatic logic [2:0] ind_code(logic hs, int s);
        if (s == 3) return 3'b111;
        if (s == 2) return hs ? 3'b010 : 3'b011;
        return 3'(s);
    endfunction

    // Comparator response of the modelled load to the applied setup.
    function automatic logic model(logic [1:0] md, int a, int b, logic i1, logic i2, logic [1:0] ps);
        logic [2:0] fp;
        logic [1:0] ip;
        if (md == 2'b00 || md == 2'b11) begin
            fp = full_pat(a);
            if (i1 && !i2) return fp[2];
            if (!i1 && i2) return fp[1];
            if (i1 && i2)  return fp[0];
            return 1'b0;
        end
        ip = ind_pat(md == 2'b10, i1 ? a : b);
        return (ps == 2'b11) ? ip[0] : ip[1];
    endfunction

    assign cmp = model(m_mode, sc1, sc2, in1, in2, psel);

    // Step trace and per-cycle line monitors.
    logic [3:0] seq [8];
    int nseq = 0;
    int run_viol = 0;
    int idle_viol = 0;
    always @(negedge clk) begin
        if (rst_n && wake) begin
            if (!doff) run_viol++;
            if (nseq == 0 || seq[nseq-1] != {in1, in2, psel}) begin
                if (nseq < 8) seq[nseq] = {in1, in2, psel};
                nseq++;
            end
        end
        if (rst_n && !busy && (wake || !doff || in1 || in2 || psel != 2'b00)) idle_viol++;
    end

    task automatic chk(string req, logic ok, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one diagnostic; optionally fire a start with other settings mid-run.
    task automatic run_case(logic [1:0] md, int a, int b, logic oc, int st, logic glitch);
        logic [2:0] e1, e2;
        int steps, stf, cyc, g;
        logic full;
        full = (md == 2'b00 || md == 2'b11);
        steps = full ? 3 : 4;
        stf = (st < 2) ? 2 : st;
        if (full) begin
            e1 = (a == 4) ? 3'b111 : 3'(a);
            e2 = e1;
        end else begin
            e1 = ind_code(md == 2'b10, a);
            e2 = ind_code(md == 2'b10, b);
        end
        if (oc && e1 == 3'b000 && e2 == 3'b000) begin e1 = 3'b100; e2 = 3'b100; end

        @(negedge clk);
        m_mode = md; sc1 = a; sc2 = b;
        load_sel = md; ocp = oc; settle = SW'(st); start = 1'b1; nseq = 0;
        @(negedge clk);
        start = 1'b0;
        chk("R11 busy after start", busy, busy, 1);
        chk("R12 results cleared", r1 == 0 && r2 == 0, {r1, r2}, 0);
        cyc = 0; g = 0;
        while (busy && cyc < 2000) begin
            cyc++;
            if (glitch && cyc == 3) begin
                start = 1'b1; load_sel = ~md; ocp = ~oc; settle = 8'd9;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk("R10 busy length", cyc == steps * (stf + 1) + 1, cyc, steps * (stf + 1) + 1);
        chk("R12 done with busy fall", done, done, 1);
        chk("R4 R6 R7 R8 R9 out1 code", r1 == e1, r1, e1);
        chk("R4 R6 R7 R8 R9 out2 code", r2 == e2, r2, e2);
        chk("R2 FETs off each step", run_viol == 0, run_viol, 0);
        chk("R3 R5 step count", nseq == steps, nseq, steps);
        if (full) begin
            chk("R3 order", seq[0] == 4'b1000 && seq[1] == 4'b0100 && seq[2] == 4'b1100,
                {seq[0], seq[1], seq[2]}, 12'h84C);
        end else begin
            chk("R5 order", seq[0] == 4'b1001 && seq[1] == 4'b1011 && seq[2] == 4'b0101 && seq[3] == 4'b0111,
                {seq[0], seq[1], seq[2], seq[3]}, 16'h9B57);
        end
        @(negedge clk);
        chk("R12 done one cycle", !done, done, 0);
        chk("R1 idle lines", idle_viol == 0, idle_viol, 0);
    endtask

    initial begin
        #(8 * 190000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset lines", !wake && doff && !in1 && !in2 && psel == 0, {wake, doff, in1, in2, psel}, 6'b010000);
        chk("R1 reset status", !busy && !done && r1 == 0 && r2 == 0, {busy, done, r1, r2}, 0);

        k = 0;
        // Full bridge: every scenario, both ocp values, both full encodings.
        for (int s = 0; s < 5; s++)
            for (int o = 0; o < 2; o++) begin
                run_case((k % 2 == 0) ? 2'b00 : 2'b11, s, 0, o[0], k % 6, 1'b0);
                k++;
            end
        // Low-side and high-side: all per-output scenario pairs, both ocp values.
        for (int hs = 0; hs < 2; hs++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    for (int o = 0; o < 2; o++) begin
                        run_case(hs ? 2'b10 : 2'b01, a, b, o[0], k % 6, 1'b0);
                        k++;
                    end
        // R11: start with other settings mid-run is ignored.
        run_case(2'b01, 1, 2, 1'b0, 4, 1'b1);
        run_case(2'b00, 0, 0, 1'b1, 3, 1'b1);

        // R12: results hold while idle inputs wander without a start.
        begin
            logic [2:0] h1, h2;
            h1 = r1; h2 = r2;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                load_sel = 2'(i); ocp = i[0]; m_mode = 2'(i); sc1 = i % 4;
            end
            chk("R12 hold out1", r1 == h1, r1, h1);
            chk("R12 hold out2", r2 == h2, r2, h2);
            chk("R1 idle after run", !busy && !wake && doff, {busy, wake, doff}, 3'b001);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule